// File: doc/BRIEF.md
# NAND Byte-Stream ECC Accumulator

This block builds Hamming-style error-correction parity over the bytes that cross a NAND flash data port. The host's data path pulses a strobe with each byte, whether the byte is headed to the flash or coming back from it. Each strobed byte is folded into four pieces of running state: a byte counter, a six-bit column parity, and two 16-bit line-parity halves, P and Q.

Software reads three values. The first is the number of bytes digested since the last clear. The second is the column parity. The third is a 32-bit line-parity word that interleaves P and Q bit by bit. Locating and correcting an error from these values is left to software. A single-cycle clear request zeroes everything so that a new page can start.

The accumulator is direction-agnostic: bytes written to the flash and bytes read back from it enter through the same strobe and update the state in the same way. The asynchronous active-low reset is released synchronously inside the block, so the state leaves reset two clock edges after the reset input rises.

Top module: `nand_ecc_accum`

## Requirements
- R1: While reset is asserted, and after it is released, the counter, the column parity and the line-parity word all read zero until a byte or clear arrives.
- R2: Each cycle with `byte_vld` high and `ecc_clr` low adds exactly one to `byte_count`, visible after that clock edge; the 16-bit counter wraps from 0xFFFF to 0x0000.
- R3: In a cycle with `byte_vld` low and `ecc_clr` low, all outputs keep their values, whatever `byte_dat` carries.
- R4: Column parity bit k (k = 0 to 5) is the running XOR, over all bytes since the last clear, of the byte bits whose bit index has bit (k/2) equal to (k mod 2). The bit masks are 0x55, 0xAA, 0x33, 0xCC, 0x0F and 0xF0 for k = 0 to 5.
- R5: For a byte whose eight bits XOR to one, P is XORed with the bitwise inverse of the byte's index and Q with the index. The index is the counter value before that byte. A byte with even bit parity leaves P and Q unchanged.
- R6: `line_parity` bit 2n equals P bit n and bit 2n+1 equals Q bit n, for n = 0 to 15.
- R7: A cycle with `ecc_clr` high zeroes the counter, the column parity and both line halves after that edge. This holds even when `byte_vld` is high in the same cycle; that byte is not accumulated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_vld | input | 1 | Strobe: one byte to digest this cycle |
| byte_dat | input | 8 | Byte crossing the data port, either direction |
| ecc_clr | input | 1 | Synchronous clear of counter and all parity state |
| byte_count | output | 16 | Bytes digested since the last clear |
| col_parity | output | 6 | Accumulated column parity |
| line_parity | output | 32 | Interleaved line parity: P on even bits, Q on odd bits |

## Verification
The assertions check several step rules on every cycle. The counter advances by exactly one per accepted byte. Idle cycles and even-parity bytes leave the line halves untouched. A zero byte leaves the column parity untouched. A clear zeroes all state one edge later. Each odd-parity byte inverts every bit of P XOR Q.

Only the bench's scenarios can show the full values. These are the actual column masks, the index-dependent P and Q contents after long and varied byte streams, the interleaved bit order of the read word, and the counter's wrap past 0xFFFF. The bench shows them by comparing against sums it computes arithmetically over a full 256-value sweep and a 65536-byte run.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned MASK_MAX_W = 64;

  // Bit i of the mask is set when bit (k/2) of i equals (k mod 2).
  function automatic logic [MASK_MAX_W-1:0] col_mask(input int unsigned k,
                                                     input int unsigned bw);
    logic [MASK_MAX_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < bw; i++) begin
      if (((i >> (k / 2)) & 1) == (k % 2)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/nand_ecc_rst_sync.sv
module nand_ecc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/nand_ecc_counter.sv
module nand_ecc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_we = clr | en;
    cnt_d  = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: one step per accepted byte, wrapping at the counter width
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3: idle cycles hold the count
  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q));

  // R7: clear zeroes the count
  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/nand_ecc_colpar.sv
module nand_ecc_colpar #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned COL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [BYTE_W-1:0] data,
  output logic [COL_W-1:0]  col
);

  import nand_ecc_pkg::*;

  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] col_d;
  logic [COL_W-1:0] hit;
  logic             col_we;

  for (genvar k = 0; k < COL_W; k++) begin : g_col
    localparam logic [MASK_MAX_W-1:0] MASK = col_mask(k, BYTE_W);
    assign hit[k] = ^(data & MASK[BYTE_W-1:0]);
  end

  always_comb begin
    col_we = clr | en;
    col_d  = col_q;
    if (clr)     col_d = '0;
    else if (en) col_d = col_q ^ hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_we) col_q <= col_d;
  end

  assign col = col_q;

  // R4: a zero byte contributes nothing to any column bit
  assert_col_zero_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && (data == '0)) |=> $stable(col_q));

  // R3: idle cycles hold the column parity
  assert_col_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(col_q));

  // R7: clear zeroes the column parity
  assert_col_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (col_q == '0));

endmodule

// File: rtl/nand_ecc_linepar.sv
module nand_ecc_linepar #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [BYTE_W-1:0] data,
  input  logic [CNT_W-1:0]  idx,
  output logic [CNT_W-1:0]  p_half,
  output logic [CNT_W-1:0]  q_half
);

  logic [CNT_W-1:0] p_q;
  logic [CNT_W-1:0] q_q;
  logic [CNT_W-1:0] p_d;
  logic [CNT_W-1:0] q_d;
  logic             odd_byte;
  logic             line_we;

  always_comb begin
    odd_byte = ^data;
    line_we  = clr | (en & odd_byte);
    p_d      = p_q;
    q_d      = q_q;
    if (clr) begin
      p_d = '0;
      q_d = '0;
    end else if (en && odd_byte) begin
      p_d = p_q ^ ~idx;
      q_d = q_q ^ idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      q_q <= '0;
    end else if (line_we) begin
      p_q <= p_d;
      q_q <= q_d;
    end
  end

  assign p_half = p_q;
  assign q_half = q_q;

  // R5: even-parity bytes leave both halves unchanged
  assert_line_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !(^data)) |=> ($stable(p_q) && $stable(q_q)));

  // R5: an odd-parity byte inverts every bit of P xor Q
  assert_line_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && (^data)) |=> ((p_q ^ q_q) == ~($past(p_q) ^ $past(q_q))));

  // R3: idle cycles hold both halves
  assert_line_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(p_q) && $stable(q_q)));

  // R7: clear zeroes both halves
  assert_line_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((p_q == '0) && (q_q == '0)));

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter  int unsigned BYTE_W = DEF_BYTE_W,
  parameter  int unsigned CNT_W  = DEF_CNT_W,
  localparam int unsigned COL_W  = 2 * $clog2(BYTE_W),
  localparam int unsigned WORD_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  input  logic              ecc_clr,
  output logic [CNT_W-1:0]  byte_count,
  output logic [COL_W-1:0]  col_parity,
  output logic [WORD_W-1:0] line_parity
);

  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] p_half;
  logic [CNT_W-1:0] q_half;

  nand_ecc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nand_ecc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (byte_vld),
    .clr   (ecc_clr),
    .cnt   (cnt)
  );

  nand_ecc_colpar #(.BYTE_W(BYTE_W), .COL_W(COL_W)) u_col (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (byte_vld),
    .clr   (ecc_clr),
    .data  (byte_dat),
    .col   (col_parity)
  );

  nand_ecc_linepar #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_line (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (byte_vld),
    .clr    (ecc_clr),
    .data   (byte_dat),
    .idx    (cnt),
    .p_half (p_half),
    .q_half (q_half)
  );

  for (genvar n = 0; n < CNT_W; n++) begin : g_weave
    assign line_parity[2*n]   = p_half[n];
    assign line_parity[2*n+1] = q_half[n];
  end

  assign byte_count = cnt;

  // R7: the read word is zero after a clear
  assert_word_clear_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ecc_clr |=> (line_parity == '0));

  // R1: during reset all outputs are zero
  always_comb begin
    if (!rst_sync_n) begin
      assert_reset_zero_R1: assert ((byte_count == '0) && (col_parity == '0) &&
                                    (line_parity == '0));
    end
  end

endmodule

// File: tb/nand_ecc_accum_test.sv
module nand_ecc_accum_test;

  logic        clk;
  logic        rst_n;
  logic        byte_vld;
  logic [7:0]  byte_dat;
  logic        ecc_clr;
  logic [15:0] byte_count;
  logic [5:0]  col_parity;
  logic [31:0] line_parity;

  int total;
  int fails;

  logic [15:0] m_cnt;
  logic [5:0]  m_cp;
  logic [15:0] m_p;
  logic [15:0] m_q;

  nand_ecc_accum uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_dat    (byte_dat),
    .ecc_clr     (ecc_clr),
    .byte_count  (byte_count),
    .col_parity  (col_parity),
    .line_parity (line_parity)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] weave(input logic [15:0] p, input logic [15:0] q);
    logic [31:0] w;
    w = '0;
    for (int n = 0; n < 16; n++) begin
      w[2*n]   = p[n];
      w[2*n+1] = q[n];
    end
    return w;
  endfunction

  task automatic model_clear();
    m_cnt = '0; m_cp = '0; m_p = '0; m_q = '0;
  endtask

  task automatic model_byte(input logic [7:0] d);
    logic [15:0] idx;
    idx = m_cnt;
    if (^d) begin
      m_p = m_p ^ ~idx;
      m_q = m_q ^ idx;
    end
    m_cp = m_cp ^ {^(d & 8'hF0), ^(d & 8'h0F), ^(d & 8'hCC),
                   ^(d & 8'h33), ^(d & 8'hAA), ^(d & 8'h55)};
    m_cnt = m_cnt + 16'd1;
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic c);
    byte_vld = v; byte_dat = d; ecc_clr = c;
    @(negedge clk);
    if (c)      model_clear();
    else if (v) model_byte(d);
    byte_vld = 1'b0; ecc_clr = 1'b0;
  endtask

  task automatic check_all(input string tag);
    total++;
    if (byte_count !== m_cnt) begin
      fails++;
      $display("FAIL %s count: actual %h expected %h", tag, byte_count, m_cnt);
    end
    total++;
    if (col_parity !== m_cp) begin
      fails++;
      $display("FAIL %s column: actual %h expected %h", tag, col_parity, m_cp);
    end
    total++;
    if (line_parity !== weave(m_p, m_q)) begin
      fails++;
      $display("FAIL %s line: actual %h expected %h", tag, line_parity, weave(m_p, m_q));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL R2 watchdog: actual 190000 cycles expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    total = 0; fails = 0;
    model_clear();
    rst_n = 1'b0; byte_vld = 1'b0; byte_dat = 8'h00; ecc_clr = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    // Single odd byte at index 0: P = FFFF, Q = 0, column = 0x15
    step(1'b1, 8'h01, 1'b0);
    check_all("R5 R6 first byte");
    total++;
    if (line_parity !== 32'h5555_5555) begin
      fails++;
      $display("FAIL R6 weave: actual %h expected 55555555", line_parity);
    end
    total++;
    if (col_parity !== 6'h15) begin
      fails++;
      $display("FAIL R4 mask: actual %h expected 15", col_parity);
    end

    // Idle cycles with junk on the data lines
    step(1'b0, 8'hFF, 1'b0);
    step(1'b0, 8'h5A, 1'b0);
    check_all("R3 idle");

    // Full sweep of byte values
    for (int v = 0; v < 256; v++) begin
      step(1'b1, v[7:0], 1'b0);
      check_all("R2 R4 R5 sweep");
    end

    // Single-bit bytes after a clear, each at a fresh index
    step(1'b0, 8'h00, 1'b1);
    check_all("R7 clear");
    for (int b = 0; b < 8; b++) begin
      step(1'b1, 8'h01 << b, 1'b0);
      check_all("R4 R5 single bit");
    end

    // Clear with a simultaneous byte: byte dropped
    step(1'b1, 8'h07, 1'b0);
    step(1'b1, 8'hFE, 1'b1);
    check_all("R7 clear priority");
    step(1'b1, 8'h80, 1'b0);
    check_all("R7 restart");

    // Long run to wrap the counter
    step(1'b0, 8'h00, 1'b1);
    for (int i = 0; i < 65535; i++) begin
      step(1'b1, 8'(i * 37 + 11), 1'b0);
    end
    check_all("R2 R5 long run");
    step(1'b1, 8'h01, 1'b0);
    check_all("R2 wrap");
    total++;
    if (byte_count !== 16'h0000) begin
      fails++;
      $display("FAIL R2 wrap count: actual %h expected 0000", byte_count);
    end
    step(1'b1, 8'h03, 1'b0);
    check_all("R2 after wrap");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule